// File: doc/BRIEF.md
# SPI Slave Response Queue

This block is the slave half of a register-mapped SPI port. Software fills a deep byte queue through a small write-only register interface. An external SPI master then clocks those bytes out on MISO, and SCK and SS are treated as asynchronous inputs. Each queued byte is shifted out most significant bit first, using the clock polarity and phase held in the configuration register. A byte leaves the queue only after all eight of its bits have been presented to the master.

Both SPI inputs pass through a synchroniser, and SCK edges are detected in the system clock domain. The external SCK must therefore be several times slower than the system clock. Slave operation is only active while the configuration register selects slave mode and SS is low. While it is active, the block drives MISO and raises an output enable. If the queue is empty when a byte starts, the block sends all ones. A control bit discards everything that is queued.

Top module: `spi_resp_slave`

## Requirements
- R1: The MISO output enable is high only while configuration bit 2 (mode) is 1 and the synchronised SS input is low. Otherwise it is low.
- R2: A write to register offset 4 appends its 8-bit value to the queue when the mode bit is 1. The same write with the mode bit at 0 is ignored.
- R3: The queue holds 512 bytes. A write that arrives while 512 bytes are held is discarded, and no stored byte changes.
- R4: Bits leave on MISO most significant bit first, and the first byte of a frame is the oldest queued byte.
- R5: A byte is removed only when its eighth bit period completes. If SS rises earlier, the same byte is sent again from its first bit in the next frame.
- R6: A byte that starts while the queue is empty is sent as 0xFF and removes nothing. A byte queued afterwards is sent in a later byte slot.
- R7: Writing control offset 1 with bit 6 set empties the queue. A byte already in flight finishes shifting but is not removed, and the clear wins over a removal in the same cycle.
- R8: Configuration bit 0 sets the SCK idle level. With 0 the leading edge rises, and with 1 it falls.
- R9: Configuration bit 1 sets the phase. With 0, the first bit is on MISO before the first leading edge and later bits change on trailing edges. With 1, each bit changes on a leading edge and is read by the master on the trailing edge.
- R10: Within one SS frame, consecutive bytes come from consecutive queue entries with no idle bit between them.
- R11: After reset the queue is empty and the configuration is 0, which means master mode, idle-low clock and phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| spi_sck_i | input | 1 | SPI clock from the external master |
| spi_ss_ni | input | 1 | SPI select from the external master, active low |
| spi_miso_o | output | 1 | Serial response data |
| spi_miso_oe_o | output | 1 | Drive enable for MISO |

## Verification
The bench acts as the SPI master in all four polarity and phase combinations and compares every sampled bit with a behavioural queue model.

It targets these corner cases:
- A frame cut off after four bits. A design that removes bytes too early would skip that byte on the retry.
- Data writes made in master mode. A design that accepts them would return stale data instead of 0xFF.
- A clear issued in the middle of a byte. A design that gave priority to the removal would corrupt the empty queue or send old data.
- More than 512 writes, followed by a frame of 513 bytes. This exposes both a dropped-write failure and a pointer that wraps over live data, because the 513th byte must read 0xFF.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic mode;   // 1 = slave
        logic cpha;
        logic cpol;
    } spi_cfg_t;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sck_i,
    input  logic ss_ni,
    output logic ss_no,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ss;
        logic              sck_last;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  sck_s;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0], sck_i};
        sync_d.ss       = {sync_q.ss[STAGES-2:0], ss_ni};
        sync_d.sck_last = sync_q.sck[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q.sck      <= '0;
            sync_q.ss       <= '1;
            sync_q.sck_last <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sck_s  = sync_q.sck[STAGES-1];
    assign ss_no  = sync_q.ss[STAGES-1];
    assign rise_o = sck_s & ~sync_q.sck_last;
    assign fall_o = ~sck_s & sync_q.sck_last;

endmodule

// File: rtl/spi_rs_fifo.sv
module spi_rs_fifo #(
    parameter int DEPTH = 512,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic          empty_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t         fifo_d, fifo_q;
    logic [W-1:0]  store [DEPTH];
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push_i && (fifo_q.cnt != CW'(DEPTH)) && !clr_i;
    assign pop_ok  = pop_i && (fifo_q.cnt != '0) && !clr_i;

    always_comb begin
        fifo_d = fifo_q;
        if (clr_i) begin
            fifo_d = '0;
        end else begin
            if (push_ok) fifo_d.wr = ptr_next(fifo_q.wr);
            if (pop_ok)  fifo_d.rd = ptr_next(fifo_q.rd);
            fifo_d.cnt = fifo_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fifo_q <= '0;
        else         fifo_q <= fifo_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) store[fifo_q.wr] <= wdata_i;
    end

    assign head_o  = store[fifo_q.rd];
    assign empty_o = (fifo_q.cnt == '0);
    assign cnt_o   = fifo_q.cnt;

endmodule

// File: rtl/spi_rs_shift.sv
module spi_rs_shift
    import spi_rs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              clr_i,
    input  logic              empty_i,
    input  logic [BYTE_W-1:0] head_i,
    output logic              pop_o,
    output logic              miso_o
);

    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [BW-1:0]     bitn;
        logic              valid;   // shreg holds a queued byte
        logic              reload;  // fetch next byte (phase 0)
        logic              act;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   lead, trail;

    assign lead  = cpol_i ? fall_i : rise_i;
    assign trail = cpol_i ? rise_i : fall_i;

    always_comb begin
        sh_d     = sh_q;
        pop_o    = 1'b0;
        sh_d.act = active_i;
        if (!active_i) begin
            sh_d.shreg  = '1;
            sh_d.bitn   = '0;
            sh_d.valid  = 1'b0;
            sh_d.reload = 1'b0;
        end else if (!sh_q.act) begin
            sh_d.bitn   = '0;
            sh_d.reload = 1'b0;
            if (!cpha_i) begin
                sh_d.shreg = empty_i ? '1 : head_i;
                sh_d.valid = !empty_i;
            end else begin
                sh_d.shreg = '1;
                sh_d.valid = 1'b0;
            end
        end else if (sh_q.reload) begin
            sh_d.shreg  = empty_i ? '1 : head_i;
            sh_d.valid  = !empty_i;
            sh_d.reload = 1'b0;
        end else if (lead && cpha_i) begin
            if (sh_q.bitn == '0) begin
                sh_d.shreg = empty_i ? '1 : head_i;
                sh_d.valid = !empty_i;
            end else begin
                sh_d.shreg = {sh_q.shreg[BYTE_W-2:0], 1'b1};
            end
        end else if (trail) begin
            if (sh_q.bitn == LAST_BIT) begin
                sh_d.bitn   = '0;
                pop_o       = sh_q.valid;
                sh_d.valid  = 1'b0;
                sh_d.reload = !cpha_i;
            end else begin
                sh_d.bitn = sh_q.bitn + 1'b1;
                if (!cpha_i) sh_d.shreg = {sh_q.shreg[BYTE_W-2:0], 1'b1};
            end
        end
        if (clr_i) sh_d.valid = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q       <= '0;
            sh_q.shreg <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign miso_o = sh_q.shreg[BYTE_W-1];

endmodule

// File: rtl/spi_resp_slave.sv
module spi_resp_slave
    import spi_rs_pkg::*;
#(
    parameter int FIFO_DEPTH  = 512,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3,
    parameter int CTRL_OFS    = 1,
    parameter int CFG_OFS     = 2,
    parameter int DATA_OFS    = 4,
    parameter int CLR_BIT     = 6,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    input  logic              spi_sck_i,
    input  logic              spi_ss_ni,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o
);

    spi_cfg_t          cfg_d, cfg_q;
    logic              ss_s, sck_rise, sck_fall, active;
    logic              fifo_push, fifo_pop, fifo_clr, fifo_empty;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              cfg_mode;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we_i && reg_addr_i == ADDR_W'(CFG_OFS)) begin
            cfg_d.cpol = reg_wdata_i[0];
            cfg_d.cpha = reg_wdata_i[1];
            cfg_d.mode = reg_wdata_i[2];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_mode  = cfg_q.mode;
    assign fifo_push = reg_we_i && reg_addr_i == ADDR_W'(DATA_OFS) && cfg_q.mode;
    assign fifo_clr  = reg_we_i && reg_addr_i == ADDR_W'(CTRL_OFS) && reg_wdata_i[CLR_BIT];
    assign active    = cfg_q.mode && !ss_s;

    spi_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sck_i  (spi_sck_i),
        .ss_ni  (spi_ss_ni),
        .ss_no  (ss_s),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    spi_rs_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (fifo_clr),
        .push_i  (fifo_push),
        .wdata_i (reg_wdata_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .cnt_o   (fifo_cnt)
    );

    spi_rs_shift u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .cpol_i   (cfg_q.cpol),
        .cpha_i   (cfg_q.cpha),
        .rise_i   (sck_rise),
        .fall_i   (sck_fall),
        .clr_i    (fifo_clr),
        .empty_i  (fifo_empty),
        .head_i   (fifo_head),
        .pop_o    (fifo_pop),
        .miso_o   (spi_miso_o)
    );

    assign spi_miso_oe_o = active;

endmodule

// File: rtl/spi_resp_slave_chk.sv
module spi_resp_slave_chk #(
    parameter int FIFO_DEPTH = 512,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             spi_miso_oe_o,
    input logic             cfg_mode,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             fifo_clr,
    input logic [CNT_W-1:0] fifo_cnt
);

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_push && !fifo_pop && !fifo_clr && fifo_cnt == CNT_W'(FIFO_DEPTH))
        |=> fifo_cnt == CNT_W'(FIFO_DEPTH));

    assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_push && !fifo_pop && !fifo_clr && fifo_cnt < CNT_W'(FIFO_DEPTH))
        |=> fifo_cnt == $past(fifo_cnt) + 1'b1);

    assert_clear_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_clr |=> fifo_cnt == '0);

    assert_pop_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop |-> fifo_cnt != '0);

    assert_oe_slave_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_miso_oe_o |-> cfg_mode);

endmodule

bind spi_resp_slave spi_resp_slave_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/test_spi_resp_slave.sv
module test_spi_resp_slave;

    localparam int H = 8;  // SCK half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       spi_sck = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic       miso, miso_oe;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;
    bit  started = 1'b0;
    int  idle_cnt = 0;

    logic [7:0] mq[$];
    bit m_mode = 1'b0, m_pha = 1'b0, m_pol = 1'b0;

    always #10 clk = ~clk;

    spi_resp_slave i_spi_resp_slave (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .reg_we_i      (we),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .spi_sck_i     (spi_sck),
        .spi_ss_ni     (spi_ss_n),
        .spi_miso_o    (miso),
        .spi_miso_oe_o (miso_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input bit mode, input bit pha, input bit pol);
        reg_write(3'd2, {5'd0, mode, pha, pol});
        m_mode = mode; m_pha = pha; m_pol = pol;
        spi_sck = pol;
        wait_cyc(4);
    endtask

    task automatic push_byte(input logic [7:0] b);
        reg_write(3'd4, b);
        if (m_mode && mq.size() < 512) mq.push_back(b);
    endtask

    task automatic clear_fifo();
        reg_write(3'd1, 8'h40);
        mq.delete();
    endtask

    // Master: nbytes per frame; stop_bit ends frame early in byte 0;
    // clr_bit issues a clear during byte 0 (phase 0 only).
    task automatic xfer(input string tag, input int nbytes,
                        input int stop_bit = -1, input int clr_bit = -1);
        logic [7:0] cur;
        bit had;
        bit aborted;
        aborted = 1'b0;
        spi_sck = m_pol;
        spi_ss_n = 1'b0;
        for (int b = 0; b < nbytes; b++) begin
            had = (mq.size() > 0);
            cur = had ? mq[0] : 8'hFF;
            for (int i = 0; i < 8; i++) begin
                if (b == 0 && i == stop_bit) begin
                    aborted = 1'b1;
                    break;
                end
                if (!m_pha) begin
                    if (b == 0 && i == clr_bit) begin
                        clear_fifo();
                        had = 1'b0;
                        wait_cyc(H - 2);
                    end else begin
                        wait_cyc(H);
                    end
                    check(tag, {7'd0, miso}, {7'd0, cur[7-i]});
                    check("R1 oe in frame", {7'd0, miso_oe}, 8'd1);
                    spi_sck = ~m_pol;
                    wait_cyc(H);
                    spi_sck = m_pol;
                end else begin
                    wait_cyc(H);
                    spi_sck = ~m_pol;
                    wait_cyc(H);
                    check(tag, {7'd0, miso}, {7'd0, cur[7-i]});
                    check("R1 oe in frame", {7'd0, miso_oe}, 8'd1);
                    spi_sck = m_pol;
                end
            end
            if (aborted) break;
            if (had) void'(mq.pop_front());
        end
        wait_cyc(H);
        spi_ss_n = 1'b1;
        wait_cyc(12);
    endtask

    // Every clock: with SS high or master mode for a while, MISO is not driven.
    always @(negedge clk) begin
        if (started) begin
            if (spi_ss_n || !m_mode) idle_cnt <= idle_cnt + 1;
            else                     idle_cnt <= 0;
            if (idle_cnt >= 4) check("R1 idle oe", {7'd0, miso_oe}, 8'd0);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        started = 1'b1;

        // R11: reset state, master mode so SS low leaves MISO undriven
        check("R11 reset oe", {7'd0, miso_oe}, 8'd0);
        spi_ss_n = 1'b0;
        wait_cyc(10);
        check("R11 master after reset", {7'd0, miso_oe}, 8'd0);
        spi_ss_n = 1'b1;
        wait_cyc(6);

        // R2: data write in master mode ignored -> slave sends 0xFF
        push_byte(8'h5A);
        set_cfg(1'b1, 1'b0, 1'b0);
        xfer("R2 master-mode write ignored", 1);

        // R4 / R10: ordered MSB-first stream, back to back
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h81);
        xfer("R4 R10 stream", 3);

        // R8 / R9: every polarity and phase
        for (int m = 0; m < 4; m++) begin
            set_cfg(1'b1, m[1], m[0]);
            push_byte(8'h96 ^ 8'(m * 37)); push_byte(8'h4E + 8'(m));
            xfer(m[0] ? "R8 R9 pol1" : "R8 R9 pol0", 2);
        end

        // R5: frame ends after 4 bits, byte resent in full
        set_cfg(1'b1, 1'b0, 1'b0);
        push_byte(8'hC3); push_byte(8'h69);
        xfer("R5 partial", 1, 4);
        xfer("R5 resend", 2);
        set_cfg(1'b1, 1'b1, 1'b1);
        push_byte(8'hE1);
        xfer("R5 partial ph1", 1, 3);
        xfer("R5 resend ph1", 1);

        // R6: empty queue sends 0xFF without popping
        set_cfg(1'b1, 1'b0, 1'b0);
        xfer("R6 empty", 1);
        push_byte(8'h42);
        xfer("R6 after empty", 2);

        // R7: clear while idle, then clear mid-byte
        push_byte(8'h11); push_byte(8'h22);
        clear_fifo();
        push_byte(8'h33);
        xfer("R7 clear idle", 2);
        push_byte(8'h77); push_byte(8'h88);
        xfer("R7 clear mid-byte", 2, -1, 3);
        xfer("R7 after clear", 1);

        // R3: 520 writes, only 512 kept; byte 513 reads 0xFF
        for (int k = 0; k < 520; k++) push_byte(8'(k * 7 + 3));
        xfer("R3 full queue", 513);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule